// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a VCO-rate clock by a 16-bit ratio N and emits one single-cycle pulse per N input cycles. The pulse feeds a phase comparator, and an identical copy drives a monitor output. A prescaler switches between divide-by-15 and divide-by-16. A 4-bit swallow counter picks the modulus, and a 12-bit main counter counts prescaler cycles and ends each output period. The prescaler is modelled as synchronous logic clocked by the VCO clock.

The ratio word is split in two. The upper 12 bits form M and the lower 4 bits form A, so N = 16·M + A. Each period has M+1 prescaler cycles. The first 16−A of them divide by 15 and the rest divide by 16. This split works only for M ≥ 15, which sets a floor of N = 240. A word below that floor is reported on a status output. All counters reload from the ratio input on the edge that ends a period, so a new word only takes effect at a period boundary.

Top module: `pulse_swallow_div`

## Requirements
- R1: For any ratio N from 240 to 65535, where M = N[15:4] and A = N[3:0], successive div_pulse assertions are exactly N clock cycles apart. This holds for every A, including 0 and 15.
- R2: div_pulse is high for exactly one clock cycle per output period.
- R3: While rst_n is sampled low, div_pulse and mon_pulse are low on the following cycle. The first div_pulse appears N cycles after the last edge at which rst_n was sampled low.
- R4: The ratio input is sampled only at reset and on the edge that ends a period, which is the same edge on which div_pulse rises. A change in the middle of a period leaves the length of that period unchanged, and the next period uses the new value.
- R5: The two boundary ratios, 240 (M=15, A=0) and 65535 (M=4095, A=15), give periods of exactly 240 and 65535 cycles.
- R6: ratio_bad is 1 exactly when the word in use for the current period has M < 15, that is N < 240. It updates only at reset and at period boundaries.
- R7: mon_pulse equals div_pulse in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO-rate input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_word | input | 16 | Latched division ratio N (M in bits 15:4, A in bits 3:0) |
| div_pulse | output | 1 | One-cycle pulse per N input cycles, to the phase comparator |
| mon_pulse | output | 1 | Monitor copy of div_pulse |
| ratio_bad | output | 1 | Word in use is below the 240 floor |

## Verification
The bench builds the block with its default widths: a 12-bit main counter and a 4-bit swallow counter, which give the 15/16 prescaler. With these widths both ends of the ratio range can be exercised within the run length. One 65535-cycle period is measured, along with repeated 240-cycle periods. Both extreme swallow counts, A=0 and A=15, are run next to the M=15 floor. Below-floor words are used only to check ratio_bad, including a word change in mid-period to show that the flag waits for the period boundary.

// File: rtl/psd_pkg.sv
// Shared types for the pulse-swallow divider.
// Assumes: nothing beyond standard SystemVerilog.
package psd_pkg;

    // Prescaler modulus: the larger divides by 2**SWAL_W, the smaller by one less.
    typedef enum logic {
        MOD_BIG   = 1'b0,
        MOD_SMALL = 1'b1
    } modulus_e;

endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler model, clocked by the VCO clock.
// Divides by 2**SWAL_W or 2**SWAL_W-1, as mod_sel selects. pre_end marks the
// last input cycle of each prescaler cycle.
// Assumes: mod_sel changes only in the cycle after a pre_end.
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int SWAL_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  modulus_e mod_sel,
    output logic     pre_end
);

    localparam logic [SWAL_W-1:0] TOP_BIG   = '1;
    localparam logic [SWAL_W-1:0] TOP_SMALL = TOP_BIG - SWAL_W'(1);

    logic [SWAL_W-1:0] pcnt;
    logic [SWAL_W-1:0] top_val;

    // Select the terminal value from the modulus and flag the last cycle.
    always_comb begin
        top_val = (mod_sel == MOD_SMALL) ? TOP_SMALL : TOP_BIG;
        pre_end = (pcnt == top_val);
    end

    // Count input cycles within one prescaler cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || pre_end) pcnt <= '0;
        else                   pcnt <= pcnt + SWAL_W'(1);
    end

    // The modulus may move only at a prescaler-cycle boundary.
    a_r1_modulus_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(mod_sel)) |-> $past(pre_end));

endmodule

// File: rtl/psd_swallow.sv
// Swallow counter. At the start of each period it loads 2**SWAL_W - A and
// holds the prescaler at the smaller modulus until that many prescaler
// cycles have ended. After that it selects the larger modulus.
// Assumes: reload is high only on a cycle where pre_end is also high.
module psd_swallow
    import psd_pkg::*;
#(
    parameter int SWAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SWAL_W-1:0] swal_new,
    input  logic              reload,
    input  logic              pre_end,
    input  logic              word_bad,
    output modulus_e          mod_sel
);

    localparam int               CNT_W = SWAL_W + 1;
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(1 << SWAL_W);

    logic [CNT_W-1:0] left;

    // Load the count of small-modulus cycles, then count them down.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)           left <= FULL - {1'b0, swal_new};
        else if (pre_end && left != '0) left <= left - CNT_W'(1);
    end

    // Use the smaller modulus while any small-modulus cycles remain.
    always_comb mod_sel = (left != '0) ? MOD_SMALL : MOD_BIG;

    // With a valid word, every small-modulus cycle is used by the end of the period.
    a_r1_swallow_spent: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !word_bad) |-> (left <= CNT_W'(1)));

endmodule

// File: rtl/psd_main.sv
// Main counter. It counts M+1 prescaler cycles per period, raises the
// terminal count on the last one, and registers the output pulses and the
// below-floor flag of the word it loads.
// Assumes: pre_end is one cycle wide.
module psd_main #(
    parameter int MAIN_W = 12,
    parameter int MIN_M  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] main_new,
    input  logic              pre_end,
    output logic              tc,
    output logic              div_q,
    output logic              mon_q,
    output logic              word_bad
);

    logic [MAIN_W-1:0] mcnt;

    // The period ends on the last input cycle of the final prescaler cycle.
    always_comb tc = pre_end && (mcnt == '0);

    // Count the remaining prescaler cycles and reload at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n || tc) mcnt <= main_new;
        else if (pre_end) mcnt <= mcnt - MAIN_W'(1);
    end

    // Register the divided pulse and its monitor copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
            mon_q <= 1'b0;
        end else begin
            div_q <= tc;
            mon_q <= tc;
        end
    end

    // Capture the below-floor flag with each word that is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n || tc) word_bad <= (main_new < MAIN_W'(MIN_M));
    end

    a_r2_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        div_q |=> !div_q);

    a_r3_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!div_q && !mon_q));

    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pre_end) && !$past(tc)) |-> (mcnt == $past(mcnt) - MAIN_W'(1)));

    a_r6_flag_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(word_bad)) |-> $past(tc));

endmodule

// File: rtl/pulse_swallow_div.sv
// Pulse-swallow divider top. It splits the ratio word into a main count
// (upper MAIN_W bits) and a swallow count (lower SWAL_W bits), then wires
// the prescaler, the swallow counter and the main counter together.
// Assumes: ratio_word is a latched word, sampled only at reset and at
// period ends.
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int MAIN_W = 12,
    parameter int SWAL_W = 4
) (
    input  logic                     clk_vco,
    input  logic                     rst_n,
    input  logic [MAIN_W+SWAL_W-1:0] ratio_word,
    output logic                     div_pulse,
    output logic                     mon_pulse,
    output logic                     ratio_bad
);

    localparam int RATIO_W = MAIN_W + SWAL_W;
    localparam int MIN_M   = (1 << SWAL_W) - 1;

    logic [MAIN_W-1:0] main_part;
    logic [SWAL_W-1:0] swal_part;
    logic              pre_end;
    logic              tc;
    modulus_e          mod_sel;

    // Split the ratio word into its main and swallow fields.
    always_comb begin
        main_part = ratio_word[RATIO_W-1:SWAL_W];
        swal_part = ratio_word[SWAL_W-1:0];
    end

    psd_prescaler #(.SWAL_W(SWAL_W)) u_pre (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .mod_sel (mod_sel),
        .pre_end (pre_end)
    );

    psd_swallow #(.SWAL_W(SWAL_W)) u_swal (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .swal_new (swal_part),
        .reload   (tc),
        .pre_end  (pre_end),
        .word_bad (ratio_bad),
        .mod_sel  (mod_sel)
    );

    psd_main #(.MAIN_W(MAIN_W), .MIN_M(MIN_M)) u_main (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .main_new (main_part),
        .pre_end  (pre_end),
        .tc       (tc),
        .div_q    (div_pulse),
        .mon_q    (mon_pulse),
        .word_bad (ratio_bad)
    );

endmodule

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module pulse_swallow_div_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ratio = 16'd240;
    logic        div_pulse, mon_pulse, ratio_bad;

    int    errors = 0;
    int    checks = 0;
    bit    sb_on  = 1'b0;
    int    gap    = -1;
    bit    prev   = 1'b0;
    int    q_n[$];
    string q_tag[$];

    always #4 clk = ~clk;

    pulse_swallow_div uut (
        .clk_vco    (clk),
        .rst_n      (rst_n),
        .ratio_word (ratio),
        .div_pulse  (div_pulse),
        .mon_pulse  (mon_pulse),
        .ratio_bad  (ratio_bad)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver side: queue the expected gap between pulses.
    task automatic push(input int n, input string tag);
        q_n.push_back(n);
        q_tag.push_back(tag);
    endtask

    // Apply reset with a new ratio; the outputs must be quiet (R3).
    task automatic start(input logic [15:0] n);
        rst_n = 1'b0;
        ratio = n;
        repeat (3) @(posedge clk);
        #2;
        chk(div_pulse == 1'b0, "R3", "div_pulse in reset", div_pulse, 0);
        chk(mon_pulse == 1'b0, "R3", "mon_pulse in reset", mon_pulse, 0);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        while (q_n.size() != 0) @(posedge clk);
        #2;
    endtask

    task automatic wait_pulse();
        @(posedge clk); #2;
        while (!div_pulse) begin
            @(posedge clk); #2;
        end
    endtask

    // Monitor: measure the gap between pulses and compare it with the queue.
    // gap starts at -1 so the first gap counts edges after the last reset edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            gap  = -1;
            prev = 1'b0;
        end else begin
            gap++;
            if (mon_pulse !== div_pulse)
                chk(1'b0, "R7", "monitor copy", mon_pulse, div_pulse);
            if (div_pulse) begin
                chk(mon_pulse == div_pulse, "R7", "monitor copy at pulse", mon_pulse, div_pulse);
                chk(!prev, "R2", "pulse width", prev, 0);
                if (sb_on) begin
                    if (q_n.size() == 0) begin
                        chk(1'b0, "R1", "unexpected pulse gap", gap, 0);
                    end else begin
                        int    e;
                        string t;
                        e = q_n.pop_front();
                        t = q_tag.pop_front();
                        chk(gap == e, t, "pulse gap", gap, e);
                    end
                end
                gap = 0;
            end
            prev = div_pulse;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 150000, 0);
        summary();
    end

    initial begin
        sb_on = 1'b1;
        // R5 upper bound; the first gap also checks R3 timing.
        push(65535, "R5");
        start(16'd65535);
        chk(ratio_bad == 1'b0, "R6", "flag for 65535", ratio_bad, 0);
        drain();
        // R5 lower bound, R3 first gap.
        push(240, "R3"); push(240, "R5"); push(240, "R5");
        start(16'd240);
        chk(ratio_bad == 1'b0, "R6", "flag for 240", ratio_bad, 0);
        drain();
        // R1 patterns: A=15 with M=240, A=0, mid values, A=15 at the floor.
        push(3855, "R1"); push(3855, "R1");
        start(16'h0F0F); drain();
        push(4656, "R1"); push(4656, "R1");
        start(16'h1230); drain();
        push(1000, "R1"); push(1000, "R1");
        start(16'd1000); drain();
        push(255, "R1"); push(255, "R1"); push(255, "R1");
        start(16'd255); drain();
        // R4: a change in mid-period waits for the boundary.
        push(300, "R4"); push(300, "R4"); push(700, "R4"); push(700, "R4");
        start(16'd300);
        wait_pulse();
        repeat (50) @(posedge clk);
        #2 ratio = 16'd700;
        drain();
        // R6: below-floor flag and when it updates.
        sb_on = 1'b0;
        start(16'd239);
        chk(ratio_bad == 1'b1, "R6", "flag for 239", ratio_bad, 1);
        start(16'd100);
        chk(ratio_bad == 1'b1, "R6", "flag for 100", ratio_bad, 1);
        repeat (5) @(posedge clk);
        #2 ratio = 16'd240;
        repeat (3) @(posedge clk);
        #2;
        chk(ratio_bad == 1'b1, "R6", "flag held mid-period", ratio_bad, 1);
        wait_pulse();
        chk(ratio_bad == 1'b0, "R6", "flag after boundary", ratio_bad, 0);
        repeat (4) @(posedge clk);
        summary();
    end

endmodule